// File: doc/BRIEF.md
# CAN Error and Overload Sequencer

This block produces the bus level a CAN node drives while it signals errors and overloads, and it tracks the interframe space between frames. It moves one step per bit-time strobe. At each strobe it reads the bus bit sampled for the bit just ended, together with pulses from the frame logic that report a detected error, the end of a frame or entry into bus-off. It then drives the next bit on `tx_bit`, where 1 is recessive, and shows its current phase on `ifs_code`.

Bit timing, frame transmission and reception, CRC and the error counter arithmetic are handled by neighbouring blocks. The frame logic reads `ifs_code` to see whether the bus is idle or a frame is in progress, and uses a return to idle after bus-off to restart. There is no data stream here, only plain control and status pins. All pulse inputs take effect only in a cycle where `bit_tick` is high.

Phase codes on `ifs_code`: 0 idle, 1 frame in progress, 2 error flag, 3 error wait-for-recessive, 4 error delimiter, 5 intermission, 6 suspend, 7 overload flag, 8 overload wait-for-recessive, 9 overload delimiter, 10 bus-off recovery.

Top module: `can_err_ovl_seq`

## Requirements
- R1: A synchronous reset puts the block in idle (code 0) with `tx_bit` at 1.
- R2: `ifs_code` changes only on a clock edge where `bit_tick` is high. Without a strobe, the values on `rx_bit`, `err_pulse` and `busoff_enter` have no effect.
- R3: `err_pulse` at a strobe moves the block to the error flag (code 2). This applies in every phase except a flag or bus-off. The flag lasts exactly FLAG_BITS (6) strobes with `tx_bit` at 0, and `err_pulse` is ignored during the flag. After the flag the block goes to error wait (code 3).
- R4: In a wait phase the block stays while the sampled bit is dominant (0). The first recessive bit moves it to the delimiter, and that bit counts as delimiter bit one. After DELIM_BITS (8) recessive bits in total, the block enters intermission (code 5).
- R5: Idle moves to frame (code 1) when a dominant bit is sampled. Frame moves to intermission when `eof_done` is high at a strobe. Intermission lasts INTERM_BITS (3) recessive bits and then returns to idle when `err_passive` is 0.
- R6: With `err_passive` at 1, the end of intermission leads to suspend (code 6). Suspend lasts SUSPEND_BITS (8) recessive bits and then returns to idle.
- R7: A dominant bit sampled on any intermission bit except the last starts an overload flag (code 7) of FLAG_BITS dominant bits. A wait phase (code 8) and an overload delimiter (code 9) follow, with the same rules as R4, and the block then returns to intermission.
- R8: A dominant bit sampled on the last intermission bit is a start of frame. The block goes to frame (code 1) and not to overload.
- R9: A dominant bit sampled during an error or overload delimiter restarts error signalling at the error flag (code 2).
- R10: `busoff_enter` at a strobe moves the block to bus-off (code 10) from any phase. The block leaves for idle only after RUN_COUNT (128) runs of RUN_BITS (11) consecutive recessive bits. A dominant bit restarts the current run, and `err_pulse` is ignored during bus-off.
- R11: `tx_bit` is 1 in every phase other than the error flag and the overload flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| rx_bit | input | 1 | Sampled bus bit, 0 dominant |
| err_pulse | input | 1 | Frame logic detected an error |
| eof_done | input | 1 | Frame logic finished end of frame |
| err_passive | input | 1 | Node is error passive |
| busoff_enter | input | 1 | Node enters bus-off |
| tx_bit | output | 1 | Bit to drive, 1 recessive |
| ifs_code | output | 4 | Current phase code |

## Verification
The bench builds the block with its default parameters: flags of 6, delimiters of 8, intermission of 3, suspend of 8, and bus-off recovery of 128 runs of 11 bits. With a strobe every four clocks, the whole 1408-bit recovery fits easily in the run. This makes the last-bit exit from bus-off observable, along with the run restart caused by a dominant bit. The exact bit counts at every boundary are also exercised: last flag bit, last delimiter bit, last intermission bit and last suspend bit.

// File: rtl/can_err_ovl_pkg.sv
package can_err_ovl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_FRAME     = 4'd1,
    ST_ERR_FLAG  = 4'd2,
    ST_ERR_WAIT  = 4'd3,
    ST_ERR_DELIM = 4'd4,
    ST_INTERM    = 4'd5,
    ST_SUSPEND   = 4'd6,
    ST_OVL_FLAG  = 4'd7,
    ST_OVL_WAIT  = 4'd8,
    ST_OVL_DELIM = 4'd9,
    ST_BUSOFF    = 4'd10
  } seq_state_t;
endpackage

// File: rtl/seq_bit_counter.sv
module seq_bit_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (en)  q <= clr ? '0 : q + 1'b1;
  end
endmodule

// File: rtl/busoff_recovery.sv
module busoff_recovery #(
  parameter int RUN_BITS  = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic rx_bit,
  output logic done
);
  localparam int RW = $clog2(RUN_BITS + 1);
  localparam int OW = $clog2(RUN_COUNT + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_BITS - 1);
  localparam logic [OW-1:0] OCC_LAST = OW'(RUN_COUNT - 1);

  logic [RW-1:0] run_q;
  logic [OW-1:0] occ_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q <= '0;
      occ_q <= '0;
    end else if (en) begin
      if (!rx_bit) begin
        run_q <= '0;
      end else if (run_q == RUN_LAST) begin
        run_q <= '0;
        occ_q <= occ_q + 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign done = en && rx_bit && (run_q == RUN_LAST) && (occ_q == OCC_LAST);
endmodule

// File: rtl/can_err_ovl_seq.sv
module can_err_ovl_seq
  import can_err_ovl_pkg::*;
#(
  parameter int FLAG_BITS    = 6,
  parameter int DELIM_BITS   = 8,
  parameter int INTERM_BITS  = 3,
  parameter int SUSPEND_BITS = 8,
  parameter int RUN_BITS     = 11,
  parameter int RUN_COUNT    = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_tick,
  input  logic       rx_bit,
  input  logic       err_pulse,
  input  logic       eof_done,
  input  logic       err_passive,
  input  logic       busoff_enter,
  output logic       tx_bit,
  output logic [3:0] ifs_code
);
  localparam int CW = $clog2(FLAG_BITS + DELIM_BITS + INTERM_BITS + SUSPEND_BITS + 1);
  localparam logic [CW-1:0] FLAG_LAST   = CW'(FLAG_BITS - 1);
  // first delimiter bit is consumed by the wait phase
  localparam logic [CW-1:0] DELIM_LAST  = CW'(DELIM_BITS - 2);
  localparam logic [CW-1:0] INTERM_LAST = CW'(INTERM_BITS - 1);
  localparam logic [CW-1:0] SUSP_LAST   = CW'(SUSPEND_BITS - 1);

  seq_state_t    state_q, state_n;
  logic [CW-1:0] cnt;
  logic          recov_done;
  logic          in_flag;

  assign in_flag = (state_q == ST_ERR_FLAG) || (state_q == ST_OVL_FLAG);

  seq_bit_counter #(.W(CW)) u_cnt (
    .clk (clk),
    .rst (rst),
    .en  (bit_tick),
    .clr (state_n != state_q),
    .q   (cnt)
  );

  busoff_recovery #(.RUN_BITS(RUN_BITS), .RUN_COUNT(RUN_COUNT)) u_recov (
    .clk    (clk),
    .rst    (rst),
    .clr    (state_q != ST_BUSOFF),
    .en     (bit_tick && (state_q == ST_BUSOFF)),
    .rx_bit (rx_bit),
    .done   (recov_done)
  );

  always_comb begin
    state_n = state_q;
    if (bit_tick) begin
      if (busoff_enter && state_q != ST_BUSOFF) begin
        state_n = ST_BUSOFF;
      end else if (err_pulse && !in_flag && state_q != ST_BUSOFF) begin
        state_n = ST_ERR_FLAG;
      end else begin
        unique case (state_q)
          ST_IDLE:      if (!rx_bit) state_n = ST_FRAME;
          ST_FRAME:     if (eof_done) state_n = ST_INTERM;
          ST_ERR_FLAG:  if (cnt == FLAG_LAST) state_n = ST_ERR_WAIT;
          ST_OVL_FLAG:  if (cnt == FLAG_LAST) state_n = ST_OVL_WAIT;
          ST_ERR_WAIT:  if (rx_bit) state_n = ST_ERR_DELIM;
          ST_OVL_WAIT:  if (rx_bit) state_n = ST_OVL_DELIM;
          ST_ERR_DELIM, ST_OVL_DELIM: begin
            if (!rx_bit)                state_n = ST_ERR_FLAG;
            else if (cnt == DELIM_LAST) state_n = ST_INTERM;
          end
          ST_INTERM: begin
            if (!rx_bit)
              state_n = (cnt == INTERM_LAST) ? ST_FRAME : ST_OVL_FLAG;
            else if (cnt == INTERM_LAST)
              state_n = err_passive ? ST_SUSPEND : ST_IDLE;
          end
          ST_SUSPEND: begin
            if (!rx_bit)               state_n = ST_FRAME;
            else if (cnt == SUSP_LAST) state_n = ST_IDLE;
          end
          ST_BUSOFF:    if (recov_done) state_n = ST_IDLE;
          default:      state_n = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_n;
  end

  assign tx_bit   = !in_flag;
  assign ifs_code = state_q;
endmodule

// File: rtl/can_err_ovl_seq_chk.sv
module can_err_ovl_seq_chk
  import can_err_ovl_pkg::*;
#(
  parameter int FLAG_BITS   = 6,
  parameter int DELIM_BITS  = 8,
  parameter int INTERM_BITS = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       bit_tick,
  input logic       rx_bit,
  input logic       err_pulse,
  input logic       busoff_enter,
  input logic       tx_bit,
  input logic [3:0] ifs_code
);
  logic [3:0]  code_q;
  logic [15:0] ticks;
  logic [15:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= ST_IDLE;
      ticks  <= '0;
    end else begin
      code_q <= ifs_code;
      if (ifs_code != code_q)   ticks <= bit_tick ? 16'd1 : 16'd0;
      else if (bit_tick && ticks != 16'hffff) ticks <= ticks + 16'd1;
    end
  end

  assign idx = (ifs_code != code_q) ? 16'd0 : ticks;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (ifs_code == ST_IDLE && tx_bit));

  p_tick_only_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(ifs_code));

  p_flag_len_r3: assert property (@(posedge clk) disable iff (rst)
    (ifs_code == ST_ERR_FLAG || ifs_code == ST_OVL_FLAG) |-> idx < 16'(FLAG_BITS));

  p_flag_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && ifs_code == ST_ERR_FLAG && idx == 16'(FLAG_BITS - 1) && !busoff_enter)
      |=> ifs_code == ST_ERR_WAIT);

  p_delim_end_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && ifs_code == ST_ERR_DELIM && rx_bit && idx == 16'(DELIM_BITS - 2)
      && !err_pulse && !busoff_enter) |=> ifs_code == ST_INTERM);

  p_overload_r7: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && ifs_code == ST_INTERM && idx < 16'(INTERM_BITS - 1) && !rx_bit
      && !err_pulse && !busoff_enter) |=> ifs_code == ST_OVL_FLAG);

  p_hard_sync_r8: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && ifs_code == ST_INTERM && idx == 16'(INTERM_BITS - 1) && !rx_bit
      && !err_pulse && !busoff_enter) |=> ifs_code == ST_FRAME);

  p_delim_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && (ifs_code == ST_ERR_DELIM || ifs_code == ST_OVL_DELIM) && !rx_bit
      && !busoff_enter) |=> ifs_code == ST_ERR_FLAG);

  p_busoff_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (ifs_code == ST_BUSOFF && !rx_bit) |=> ifs_code == ST_BUSOFF);

  p_tx_recessive_r11: assert property (@(posedge clk) disable iff (rst)
    (ifs_code != ST_ERR_FLAG && ifs_code != ST_OVL_FLAG) |-> tx_bit);
endmodule

bind can_err_ovl_seq can_err_ovl_seq_chk #(
  .FLAG_BITS   (FLAG_BITS),
  .DELIM_BITS  (DELIM_BITS),
  .INTERM_BITS (INTERM_BITS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bit_tick     (bit_tick),
  .rx_bit       (rx_bit),
  .err_pulse    (err_pulse),
  .busoff_enter (busoff_enter),
  .tx_bit       (tx_bit),
  .ifs_code     (ifs_code)
);

// File: tb/can_err_ovl_seq_tb.sv
module can_err_ovl_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_tick = 1'b0;
  logic       rx_bit = 1'b1;
  logic       err_pulse = 1'b0;
  logic       eof_done = 1'b0;
  logic       err_passive = 1'b0;
  logic       busoff_enter = 1'b0;
  logic       tx_bit;
  logic [3:0] ifs_code;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  localparam logic [3:0] C_IDLE = 4'd0, C_FRAME = 4'd1, C_EFLAG = 4'd2,
    C_EWAIT = 4'd3, C_EDELIM = 4'd4, C_INTERM = 4'd5, C_SUSP = 4'd6,
    C_OFLAG = 4'd7, C_OWAIT = 4'd8, C_ODELIM = 4'd9, C_BUSOFF = 4'd10;

  always #2 clk = ~clk;

  can_err_ovl_seq u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .err_pulse(err_pulse), .eof_done(eof_done), .err_passive(err_passive),
    .busoff_enter(busoff_enter), .tx_bit(tx_bit), .ifs_code(ifs_code)
  );

  task automatic check(input logic [3:0] exp_code, input logic exp_tx, input string req);
    n_chk++;
    if (ifs_code !== exp_code || tx_bit !== exp_tx) begin
      n_bad++;
      $display("FAIL %s: code=%0d tx=%0b expected code=%0d tx=%0b",
               req, ifs_code, tx_bit, exp_code, exp_tx);
    end
  endtask

  task automatic send(input logic rx, input logic err = 1'b0,
                      input logic eof = 1'b0, input logic boff = 1'b0);
    @(negedge clk);
    rx_bit = rx; err_pulse = err; eof_done = eof; busoff_enter = boff;
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0; err_pulse = 1'b0; eof_done = 1'b0; busoff_enter = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendn(input logic rx, input int n);
    for (int i = 0; i < n; i++) send(rx);
  endtask

  task automatic to_interm();
    send(1'b0);
    send(1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(C_IDLE, 1'b1, "R1 reset");
  endtask

  task automatic t_no_tick();
    @(negedge clk);
    rx_bit = 1'b0; err_pulse = 1'b1; busoff_enter = 1'b1;
    repeat (4) @(negedge clk);
    err_pulse = 1'b0; busoff_enter = 1'b0; rx_bit = 1'b1;
    check(C_IDLE, 1'b1, "R2 no strobe");
  endtask

  task automatic t_normal();
    send(1'b0);
    check(C_FRAME, 1'b1, "R5 idle to frame");
    sendn(1'b1, 3);
    check(C_FRAME, 1'b1, "R5 frame holds");
    send(1'b1, 1'b0, 1'b1);
    check(C_INTERM, 1'b1, "R5 eof to intermission");
    sendn(1'b1, 2);
    check(C_INTERM, 1'b1, "R5 intermission bit 3 pending");
    send(1'b1);
    check(C_IDLE, 1'b1, "R5 back to idle");
  endtask

  task automatic finish_error_from_flag();
    sendn(1'b0, 6);
    sendn(1'b1, 8);
    sendn(1'b1, 3);
  endtask

  task automatic t_error();
    send(1'b0);
    send(1'b1, 1'b1);
    check(C_EFLAG, 1'b0, "R3 flag start");
    send(1'b0, 1'b1);
    sendn(1'b0, 4);
    check(C_EFLAG, 1'b0, "R3 flag bit 6 still driven");
    send(1'b0);
    check(C_EWAIT, 1'b1, "R3 flag ends after 6");
    sendn(1'b0, 3);
    check(C_EWAIT, 1'b1, "R4 wait while dominant");
    send(1'b1);
    check(C_EDELIM, 1'b1, "R4 first recessive");
    sendn(1'b1, 6);
    check(C_EDELIM, 1'b1, "R4 delimiter bit 8 pending");
    send(1'b1);
    check(C_INTERM, 1'b1, "R4 delimiter ends after 8");
    sendn(1'b1, 3);
    check(C_IDLE, 1'b1, "R5 idle after error");
  endtask

  task automatic t_passive();
    err_passive = 1'b1;
    to_interm();
    sendn(1'b1, 3);
    check(C_SUSP, 1'b1, "R6 suspend entered");
    sendn(1'b1, 7);
    check(C_SUSP, 1'b1, "R6 suspend bit 8 pending");
    send(1'b1);
    check(C_IDLE, 1'b1, "R6 suspend ends after 8");
    err_passive = 1'b0;
  endtask

  task automatic t_overload();
    to_interm();
    send(1'b0);
    check(C_OFLAG, 1'b0, "R7 overload on first intermission bit");
    sendn(1'b0, 5);
    check(C_OFLAG, 1'b0, "R7 overload flag bit 6");
    send(1'b0);
    check(C_OWAIT, 1'b1, "R7 overload wait");
    send(1'b0);
    check(C_OWAIT, 1'b1, "R7 wait holds");
    send(1'b1);
    sendn(1'b1, 6);
    check(C_ODELIM, 1'b1, "R7 overload delimiter");
    send(1'b1);
    check(C_INTERM, 1'b1, "R7 back to intermission");
    send(1'b1);
    send(1'b0);
    check(C_OFLAG, 1'b0, "R7 overload on second intermission bit");
    sendn(1'b0, 6);
    sendn(1'b1, 8);
    sendn(1'b1, 3);
    check(C_IDLE, 1'b1, "R7 idle after overload");
  endtask

  task automatic t_hard_sync();
    to_interm();
    sendn(1'b1, 2);
    send(1'b0);
    check(C_FRAME, 1'b1, "R8 last intermission bit is start of frame");
    send(1'b1, 1'b0, 1'b1);
    sendn(1'b1, 3);
    check(C_IDLE, 1'b1, "R8 idle after frame");
  endtask

  task automatic t_delim_restart();
    send(1'b0);
    send(1'b1, 1'b1);
    sendn(1'b0, 6);
    sendn(1'b1, 3);
    send(1'b0);
    check(C_EFLAG, 1'b0, "R9 dominant in delimiter restarts flag");
    finish_error_from_flag();
    check(C_IDLE, 1'b1, "R9 idle after restart");
  endtask

  task automatic t_busoff();
    send(1'b0);
    send(1'b1, 1'b0, 1'b0, 1'b1);
    check(C_BUSOFF, 1'b1, "R10 bus-off entered");
    send(1'b0, 1'b1);
    check(C_BUSOFF, 1'b1, "R10 error ignored in bus-off");
    sendn(1'b1, 10);
    send(1'b0);
    check(C_BUSOFF, 1'b1, "R10 broken run");
    sendn(1'b1, 128 * 11 - 1);
    check(C_BUSOFF, 1'b1, "R10 one bit short");
    send(1'b1);
    check(C_IDLE, 1'b1, "R10 recovery complete");
  endtask

  initial begin
    t_reset();
    t_no_tick();
    t_normal();
    t_error();
    t_passive();
    t_overload();
    t_hard_sync();
    t_delim_restart();
    t_busoff();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, code=%0d expected progress", ifs_code);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule